// File: doc/BRIEF.md
# Serial Memory Command Engine

This block is the slave side of a four-wire serial link in front of a small byte-wide memory. It runs on a fast system clock and oversamples the serial clock, select, data-in and pause pins. Data is taken in on each rising serial clock edge and driven out after each falling edge, most significant bit first. Each transfer starts when select goes low. The first byte is a command. For memory commands, two address bytes follow, and then a stream of data bytes.

A read returns bytes from a running address that advances by one after each byte and wraps over the whole array. A write collects bytes into a page buffer. The low address bits advance inside one page. The page is committed to the array only when select rises cleanly on a byte boundary and the write-enable latch was set. The commit runs for a fixed number of system clocks. During that time only the status command is served. A pause input freezes a transfer mid-stream without losing its place. An unknown command silences the device until the next transfer.

Top module: `msp_cmd_engine`

## Requirements
- R1: After reset the output enable is low and the status byte reads 0x00.
- R2: Command decoding ignores bit 3 and needs bits 7..4 to be zero. Low three bits 110 sets the write-enable latch, 100 clears it, 101 reads status, 001 writes status, 011 reads memory and 010 writes memory. So 0x0E acts as 0x06 and 0x0B acts as 0x03.
- R3: The status byte has busy in bit 0, the write-enable latch in bit 1 and a six-bit user field in bits 7..2. The status command streams it repeatedly, and each byte reflects the current state.
- R4: A read takes a 16-bit address, high byte first. The low log2(DEPTH) bits select the location. The addressed byte is shifted out MSB first after the following falling edges, and the address advances by one for each further byte.
- R5: A read stream wraps from address DEPTH-1 to address 0.
- R6: A memory write issued while the write-enable latch is clear changes nothing and starts no busy period.
- R7: Write data lands at the running address, whose low log2(PAGE) bits wrap inside the page. A later byte for the same location replaces an earlier one. The page is committed when select rises on a byte boundary, and the latch is then clear.
- R8: If select rises while a data byte is incomplete, the write is discarded and the latch stays set.
- R9: While a commit is busy, status bit 0 reads 1 and every command other than status read is ignored, with SO left disabled.
- R10: After an unknown command, SO stays disabled and further input has no effect until select falls again.
- R11: While select is high, SO is disabled and serial clock and data activity has no effect.
- R12: Pulling the pause input low while the serial clock is low freezes the bit position and SO and disables SO. Clock edges during the pause are ignored. Releasing the pause while the clock is low resumes the same byte.
- R13: A status write with the latch set loads data bits 7..2 into the user field and clears the latch. Without the latch it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are oversampled by it |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Active-low select; each falling edge starts a command |
| spi_si | input | 1 | Serial data into the block |
| spi_hold_n | input | 1 | Active-low pause of the current transfer |
| spi_so | output | 1 | Serial data out of the block |
| spi_so_oe | output | 1 | Output enable for spi_so, high when the pin is driven |

## Verification
A wrong bit count or a lost pause state shows up as a read byte that is shifted or rotated at the first compared byte. An address pointer that wraps at the wrong width shows up when a stream crosses a page or the top of the array. A page buffer that keeps stale valid bits, or that commits without the latch, shows up as corrupted memory on the next read-back. That read can be long after the transfer that caused it, so every write is read back at once. A stuck busy flag or a missed mute shows up within one byte, as status bit 0 or as the output enable.

// File: rtl/msp_pkg.sv
package msp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADDR, PH_RDATA, PH_WDATA, PH_SRD, PH_SWR, PH_MUTE
  } phase_e;

  typedef enum logic [2:0] {
    OP_SETWE, OP_CLRWE, OP_RDST, OP_WRST, OP_RD, OP_WR, OP_BAD
  } op_e;

  // bit 3 is don't-care, upper nibble must be zero
  function automatic op_e decode_op(input logic [7:0] b);
    if (b[7:4] != 4'h0) return OP_BAD;
    case (b[2:0])
      3'b110:  return OP_SETWE;
      3'b100:  return OP_CLRWE;
      3'b101:  return OP_RDST;
      3'b001:  return OP_WRST;
      3'b011:  return OP_RD;
      3'b010:  return OP_WR;
      default: return OP_BAD;
    endcase
  endfunction

endpackage

// File: rtl/msp_link.sv
module msp_link (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  output logic sel,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s,
  output logic held
);
  logic s_sck, p_sck, s_cs, p_cs, s_hold, s_si;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_sck <= 1'b0; p_sck <= 1'b0;
      s_cs <= 1'b1;  p_cs <= 1'b1;
      s_si <= 1'b0;  s_hold <= 1'b1;
      held <= 1'b0;
    end else begin
      s_sck <= sck;  p_sck <= s_sck;
      s_cs <= cs_n;  p_cs <= s_cs;
      s_si <= si;    s_hold <= hold_n;
      if (s_cs)        held <= 1'b0;
      else if (!s_sck) held <= !s_hold;   // pause only changes with clock low
    end
  end

  assign sel      = !s_cs;
  assign cs_fall  = p_cs && !s_cs;
  assign cs_rise  = !p_cs && s_cs;
  assign sck_rise = sel && !held && s_sck && !p_sck;
  assign sck_fall = sel && !held && !s_sck && p_sck;
  assign si_s     = s_si;
endmodule

// File: rtl/msp_array.sv
module msp_array #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/msp_pagebuf.sv
module msp_pagebuf #(
  parameter int AW          = 10,
  parameter int PAGE        = 16,
  parameter int COMMIT_WAIT = 600
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [7:0]    push_data,
  input  logic          start,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata
);
  localparam int PW = $clog2(PAGE);
  localparam int WW = $clog2(COMMIT_WAIT + 1);

  typedef enum logic [1:0] {PB_IDLE, PB_FLUSH, PB_WAIT} pb_state_e;

  logic [7:0]       pbuf [PAGE];
  logic [PAGE-1:0]  vld;
  logic [AW-PW-1:0] base;
  logic [PW-1:0]    idx;
  logic [WW-1:0]    cnt;
  pb_state_e        st;

  always_ff @(posedge clk) begin
    if (push) pbuf[push_addr[PW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= PB_IDLE; vld <= '0; base <= '0; idx <= '0; cnt <= '0;
      mem_we <= 1'b0; mem_waddr <= '0; mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      case (st)
        PB_IDLE: begin
          if (start) begin
            st  <= PB_FLUSH;
            idx <= '0;
          end else begin
            if (clear) vld <= '0;
            if (push) begin
              vld[push_addr[PW-1:0]] <= 1'b1;
              base <= push_addr[AW-1:PW];
            end
          end
        end
        PB_FLUSH: begin
          mem_we    <= vld[idx];
          mem_waddr <= {base, idx};
          mem_wdata <= pbuf[idx];
          idx       <= idx + 1'b1;
          if (idx == PW'(PAGE - 1)) begin
            st  <= PB_WAIT;
            cnt <= '0;
          end
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == WW'(COMMIT_WAIT - 1)) begin
            st  <= PB_IDLE;
            vld <= '0;
          end
        end
      endcase
    end
  end

  assign busy = (st != PB_IDLE);
endmodule

// File: rtl/msp_cmd_engine.sv
module msp_cmd_engine #(
  parameter int DEPTH       = 1024,
  parameter int PAGE        = 16,
  parameter int COMMIT_WAIT = 600
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_si,
  input  logic spi_hold_n,
  output logic spi_so,
  output logic spi_so_oe
);
  import msp_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);

  logic sel, cs_fall, cs_rise, sck_rise, sck_fall, si_s, held;
  logic pb_busy, push, start, mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0] mem_wdata, rd_data;

  phase_e phase;
  op_e op;
  logic [2:0] bitcnt;
  logic [6:0] sh;
  logic [7:0] osh;
  logic [AW-1:0] abuf, cur;
  logic acnt, is_wr, got, wel, pend1, pend2, so_q, oe_q;
  logic [5:0] user, user_nxt;

  wire [7:0]    byte_in   = {sh, si_s};
  wire [AW-1:0] addr_in   = {abuf[AW-2:0], si_s};
  wire          byte_done = sck_rise && (bitcnt == 3'd7);
  wire [7:0]    status    = {user, wel, pb_busy};
  wire          rd_phase  = (phase == PH_RDATA) || (phase == PH_SRD);

  assign op    = decode_op(byte_in);
  assign push  = (phase == PH_WDATA) && byte_done;
  assign start = cs_rise && (phase == PH_WDATA) && got && (bitcnt == 3'd0) && !pb_busy;

  msp_link u_link (
    .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .si(spi_si),
    .hold_n(spi_hold_n), .sel(sel), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s), .held(held)
  );

  msp_pagebuf #(.AW(AW), .PAGE(PAGE), .COMMIT_WAIT(COMMIT_WAIT)) u_page (
    .clk(clk), .rst(rst), .clear(cs_fall), .push(push), .push_addr(cur),
    .push_data(byte_in), .start(start), .busy(pb_busy), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  msp_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(cur), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE; bitcnt <= '0; sh <= '0; osh <= '0; abuf <= '0;
      acnt <= 1'b0; cur <= '0; is_wr <= 1'b0; got <= 1'b0; wel <= 1'b0;
      user <= '0; user_nxt <= '0; pend1 <= 1'b0; pend2 <= 1'b0;
      so_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      pend1 <= 1'b0;
      pend2 <= pend1;
      oe_q  <= sel && !held && rd_phase;
      if (pend2) osh <= rd_data;
      else if (sck_fall && rd_phase) begin
        so_q <= osh[7];
        osh  <= {osh[6:0], 1'b0};
      end
      if (cs_fall) begin
        phase <= PH_OPC; bitcnt <= '0; acnt <= 1'b0; got <= 1'b0;
      end else if (cs_rise) begin
        if (start) wel <= 1'b0;
        if (phase == PH_SWR && got && bitcnt == 3'd0) begin
          user <= user_nxt;
          wel  <= 1'b0;
        end
        phase  <= PH_IDLE;
        bitcnt <= '0;
      end else if (sck_rise) begin
        sh     <= byte_in[6:0];
        bitcnt <= bitcnt + 1'b1;
        case (phase)
          PH_OPC: if (byte_done) begin
            if (pb_busy && op != OP_RDST) phase <= PH_IDLE;
            else begin
              case (op)
                OP_SETWE: begin wel <= 1'b1; phase <= PH_IDLE; end
                OP_CLRWE: begin wel <= 1'b0; phase <= PH_IDLE; end
                OP_RDST:  begin osh <= status; phase <= PH_SRD; end
                OP_WRST:  phase <= wel ? PH_SWR : PH_IDLE;
                OP_RD:    begin is_wr <= 1'b0; phase <= PH_ADDR; end
                OP_WR:    begin is_wr <= 1'b1; phase <= wel ? PH_ADDR : PH_IDLE; end
                default:  phase <= PH_MUTE;
              endcase
            end
          end
          PH_ADDR: begin
            abuf <= addr_in;
            if (byte_done) begin
              acnt <= 1'b1;
              if (acnt) begin
                cur <= addr_in;
                if (is_wr) phase <= PH_WDATA;
                else begin
                  phase <= PH_RDATA;
                  pend1 <= 1'b1;
                end
              end
            end
          end
          PH_RDATA: if (byte_done) begin
            cur   <= cur + 1'b1;
            pend1 <= 1'b1;
          end
          PH_WDATA: if (byte_done) begin
            got         <= 1'b1;
            cur[PW-1:0] <= cur[PW-1:0] + 1'b1;
          end
          PH_SRD: if (byte_done) osh <= status;
          PH_SWR: if (byte_done) begin
            got      <= 1'b1;
            user_nxt <= byte_in[7:2];
          end
          default: ;
        endcase
      end
    end
  end

  assign spi_so    = so_q;
  assign spi_so_oe = oe_q;
endmodule

// File: rtl/msp_cmd_chk.sv
module msp_cmd_chk (
  input logic            clk,
  input logic            rst,
  input logic            cs_n,
  input logic            so,
  input logic            so_oe,
  input logic            busy,
  input logic            wel,
  input logic            held,
  input logic [2:0]      bitcnt,
  input msp_pkg::phase_e phase
);
  import msp_pkg::*;

  assert_cs_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n, 2) |-> !so_oe);

  assert_mute_silent_R10: assert property (@(posedge clk) disable iff (rst)
    $past(phase == PH_MUTE) |-> !so_oe);

  assert_commit_needs_latch_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel));

  assert_busy_blocks_read_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (phase != PH_RDATA));

  assert_hold_freezes_R12: assert property (@(posedge clk) disable iff (rst)
    (held && $past(held)) |-> ($stable(bitcnt) && $stable(so)));
endmodule

bind msp_cmd_engine msp_cmd_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(spi_cs_n), .so(spi_so), .so_oe(spi_so_oe),
  .busy(pb_busy), .wel(wel), .held(held), .bitcnt(bitcnt), .phase(phase)
);

// File: tb/tb_msp_cmd_engine.sv
module tb_msp_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 6;
  localparam int DEPTH = 1024;
  localparam int PAGE  = 16;
  localparam int WAITC = 600;

  logic clk = 0, rst = 1, sck = 0, cs_n = 1, si = 0, hold_n = 1;
  logic so, so_oe;
  int checks = 0, errors = 0;
  logic [7:0] sb [DEPTH];
  logic [7:0] exp_q [$];
  string req_q [$];
  bit mon_on = 0, mon_bad = 0;
  logic [7:0] mon_sh = 0;
  int mon_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msp_cmd_engine #(.DEPTH(DEPTH), .PAGE(PAGE), .COMMIT_WAIT(WAITC)) dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_hold_n(hold_n), .spi_so(so), .spi_so_oe(so_oe)
  );

  // monitor: assembles bytes seen by the master and pops the scoreboard
  always @(posedge sck) if (mon_on) begin
    if (so_oe !== 1'b1) mon_bad = 1;
    mon_sh = {mon_sh[6:0], so};
    mon_n++;
    if (mon_n == 8) begin
      logic [7:0] e;
      string r;
      mon_n = 0;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if (mon_bad || mon_sh !== e) begin
        errors++;
        $display("FAIL %s read byte: actual=%02h expected=%02h (oe_missing=%0d)", r, mon_sh, e, mon_bad);
      end
      mon_bad = 0;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic r);
    si = b;
    repeat (HALF) @(negedge clk);
    r = so;
    sck = 1;
    repeat (HALF) @(negedge clk);
    sck = 0;
  endtask

  task automatic sel_on();
    @(negedge clk); cs_n = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel_off();
    repeat (HALF) @(negedge clk); cs_n = 1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] tx);
    logic r;
    for (int i = 7; i >= 0; i--) bitx(tx[i], r);
  endtask

  task automatic get_exp(input logic [7:0] e, input string req);
    exp_q.push_back(e); req_q.push_back(req);
    mon_on = 1; put(8'h00); mon_on = 0;
  endtask

  task automatic get_raw(output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin bitx(1'b0, r); v[i] = r; end
  endtask

  task automatic quiet_byte(input logic [7:0] tx, input string req);
    bit bad = 0;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      repeat (HALF) @(negedge clk);
      if (so_oe !== 1'b0) bad = 1;
      sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
    check(!bad, req, "so_oe during ignored byte", bad, 0);
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel_on(); put(op); sel_off();
  endtask

  task automatic status_exp(input logic [7:0] e, input string req);
    sel_on(); put(8'h05); get_exp(e, req); sel_off();
  endtask

  task automatic wait_ready();
    logic [7:0] v;
    sel_on(); put(8'h05);
    for (int k = 0; k < 60; k++) begin get_raw(v); if (!v[0]) break; end
    sel_off();
  endtask

  task automatic write_bytes(input int a, input int n, input logic [7:0] first,
                             input logic [7:0] step, input bit upd);
    sel_on(); put(8'h02); put(a[15:8]); put(a[7:0]);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = first + 8'(i) * step;
      put(d);
      if (upd) sb[(a & ~(PAGE-1)) | ((a + i) & (PAGE-1))] = d;
    end
    sel_off();
  endtask

  task automatic read_exp(input int a, input int n, input string req, input logic [7:0] op);
    sel_on(); put(op); put(a[15:8]); put(a[7:0]);
    for (int i = 0; i < n; i++) get_exp(sb[(a + i) % DEPTH], req);
    sel_off();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic r;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    check(so_oe === 1'b0, "R1", "so_oe after reset", so_oe, 0);
    status_exp(8'h00, "R1");
    // R3: latch set / clear visible in status bit 1
    cmd1(8'h06); status_exp(8'h02, "R3");
    cmd1(8'h04); status_exp(8'h00, "R3");
    cmd1(8'h0E); status_exp(8'h02, "R2");          // R2: bit 3 ignored
    // R7: page write, R9: busy flag and ignored read
    write_bytes(16'h0004, 4, 8'h31, 8'h17, 1);
    status_exp(8'h01, "R9");
    sel_on(); put(8'h03); put(8'h00); put(8'h04); quiet_byte(8'h00, "R9"); sel_off();
    wait_ready();
    status_exp(8'h00, "R7");
    read_exp(16'h0004, 4, "R4", 8'h03);
    read_exp(16'h0005, 2, "R2", 8'h0B);
    // R7: wrap inside the page, later bytes replace earlier ones
    cmd1(8'h06); write_bytes(16'h000D, PAGE + 2, 8'hA0, 8'h03, 1); wait_ready();
    read_exp(16'h0000, PAGE, "R7", 8'h03);
    // R5: read stream wraps over the array top
    cmd1(8'h06); write_bytes(DEPTH - 2, 2, 8'h5A, 8'h11, 1); wait_ready();
    read_exp(DEPTH - 2, 4, "R5", 8'h03);
    // R6: write without latch
    write_bytes(16'h0004, 1, 8'hEE, 8'h00, 0);
    status_exp(8'h00, "R6");
    read_exp(16'h0004, 1, "R6", 8'h03);
    // R8: select rises mid-byte
    cmd1(8'h06);
    sel_on(); put(8'h02); put(8'h00); put(8'h05); put(8'h99);
    bitx(1'b1, r); bitx(1'b0, r); bitx(1'b1, r);
    sel_off();
    status_exp(8'h02, "R8");
    read_exp(16'h0005, 1, "R8", 8'h03);
    // R10: unknown command mutes the rest of the transfer
    sel_on(); quiet_byte(8'hA5, "R10"); quiet_byte(8'h03, "R10");
    quiet_byte(8'h00, "R10"); quiet_byte(8'h04, "R10"); sel_off();
    status_exp(8'h02, "R10");
    // R11: activity with select high
    put(8'h04); quiet_byte(8'h00, "R11");
    status_exp(8'h02, "R11");
    // R12: pause in the middle of a read byte
    sel_on(); put(8'h03); put(8'h00); put(8'h04);
    exp_q.push_back(sb[4]); req_q.push_back("R12");
    mon_on = 1; for (int i = 0; i < 4; i++) bitx(1'b0, r); mon_on = 0;
    hold_n = 0;
    repeat (HALF) @(negedge clk);
    check(so_oe === 1'b0, "R12", "so_oe while paused", so_oe, 0);
    for (int i = 0; i < 3; i++) bitx(i[0], r);
    check(so_oe === 1'b0, "R12", "so_oe after clocks in pause", so_oe, 0);
    hold_n = 1;
    repeat (HALF) @(negedge clk);
    mon_on = 1; for (int i = 0; i < 4; i++) bitx(1'b0, r); mon_on = 0;
    get_exp(sb[5], "R12");
    sel_off();
    // R13: status write with and without latch
    cmd1(8'h06);
    sel_on(); put(8'h01); put(8'hA9); sel_off();
    status_exp(8'hA8, "R13");
    sel_on(); put(8'h01); put(8'h54); sel_off();
    status_exp(8'hA8, "R13");
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule